// File: doc/BRIEF.md
# Challenge-Response Authentication Register Front-End

This block is the register side of a battery-pack authentication device. A host bus decoder hands it single-byte reads and writes, each addressed by a two-bit page and a four-bit offset. The host first picks which of three built-in 32-bit secrets act as the seed and which act as the coefficient. It then sends a 32-bit challenge as four byte writes. When the fourth byte arrives, a keyed function with a fixed latency starts. Its 8-bit answer can be fetched exactly once. A status register reports busy, error and completion, and reading it clears the sticky bits.

The block enforces the order of the protocol. A new secret selection must come before every challenge. A partly sent challenge is dropped when the selection is rewritten. Invalid selection codes, writes made while the engine runs, early reads and repeated reads are all refused, and each sets the error flag.

Top module: `auth_regfront`

## Requirements
- R1: After reset the selection register reads 0x06 (coefficient field 01, seed field 10) and the status register reads 0x00.
- R2: The selection register is at page 2, offset 0. Bits 3:2 are the coefficient code and bits 1:0 the seed code. Codes 1, 2 and 3 pick secrets 0xA5C31E69, 0x3C96F00D and 0x7E1592B4, and bits 7:4 read as 0. A write that has 00 in either field leaves the register unchanged and sets the error bit.
- R3: The challenge port is at page 2, offset 1. Four writes fill it from the least significant byte upward, the fourth write starts the engine, and reads of the port return 0x00.
- R4: Status bit 0 (busy) reads 1 for exactly 8 cycles after the start edge. The result is then readable at page 2, offset 5, and status bit 2 (done) is set.
- R5: The result is computed from h = seed ^ challenge. Eight steps i = 0..7 are applied, each h = rotl(h,3) ^ (coef + i). The result is the XOR of the four bytes of h.
- R6: The result can be read once. Any later read, or a read when no result exists, returns 0x00 and sets the error bit.
- R7: A result read while busy returns 0x00 and sets the error bit.
- R8: A fourth challenge byte with no valid selection write since the last start (or since reset) does not start the engine and sets the error bit.
- R9: A valid selection write discards any challenge bytes already collected.
- R10: The status register is at page 1, offset 1 (bit 1 is error). A read clears error and done. If an event that sets one of these bits happens in the same cycle as the read, the bit is still set afterwards.
- R11: Selection or challenge writes made while busy are ignored and set the error bit.
- R12: Other addresses read as 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| page | input | 2 | Register page |
| offset | input | 4 | Register offset within page |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid in the cycle rd_en is high |

## Verification
Two things can meet in one cycle: a status read that clears done, and the engine finishing, which sets done. The bench polls the status register on every cycle after the start. The eighth poll therefore falls on the finishing edge. That poll must show busy without done, and the next poll must show done. If the clear won over the set, the completion would be lost, and the ninth poll would expose it.

// File: rtl/auth_regfront.sv
module auth_regfront #(
  parameter logic [31:0] SECRET1 = 32'hA5C3_1E69,
  parameter logic [31:0] SECRET2 = 32'h3C96_F00D,
  parameter logic [31:0] SECRET3 = 32'h7E15_92B4,
  parameter int          STEPS   = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [1:0] page,
  input  logic [3:0] offset,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data
);
  localparam int SW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  function automatic logic [31:0] key_of(input logic [1:0] code);
    case (code)
      2'd1:    return SECRET1;
      2'd2:    return SECRET2;
      default: return SECRET3;
    endcase
  endfunction

  logic [1:0]    coef_sel, seed_sel;
  logic [31:0]   coef_key, seed_key, chal, h;
  logic [1:0]    nbyte;
  logic [SW-1:0] step;
  logic          busy, err, done, rdy, fresh;

  wire a_sel  = page == 2'd2 && offset == 4'h0;
  wire a_chl  = page == 2'd2 && offset == 4'h1;
  wire a_auth = page == 2'd2 && offset == 4'h5;
  wire a_stat = page == 2'd1 && offset == 4'h1;

  wire wr_sel    = wr_en && a_sel;
  wire wr_chl    = wr_en && a_chl;
  wire rd_auth   = rd_en && a_auth;
  wire rd_stat   = rd_en && a_stat;
  wire sel_ok    = wr_data[3:2] != 2'd0 && wr_data[1:0] != 2'd0;
  wire last_byte = wr_chl && !busy && nbyte == 2'd3;
  wire start     = last_byte && fresh;
  wire finish    = busy && step == LAST;
  wire [7:0] fold = h[31:24] ^ h[23:16] ^ h[15:8] ^ h[7:0];

  wire err_evt = (wr_sel && (busy || !sel_ok)) || (wr_chl && busy) ||
                 (last_byte && !fresh) || (rd_auth && (busy || !rdy));

  always_comb begin
    rd_data = 8'h00;
    if (rd_en) begin
      if (a_sel)       rd_data = {4'h0, coef_sel, seed_sel};
      else if (a_stat) rd_data = {5'h00, done, err, busy};
      else if (a_auth) rd_data = (rdy && !busy) ? fold : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      coef_sel <= 2'd1;
      seed_sel <= 2'd2;
      coef_key <= '0;
      seed_key <= '0;
      chal     <= '0;
      h        <= '0;
      nbyte    <= '0;
      step     <= '0;
      busy     <= 1'b0;
      err      <= 1'b0;
      done     <= 1'b0;
      rdy      <= 1'b0;
      fresh    <= 1'b0;
    end else begin
      err  <= err_evt || (err && !rd_stat);
      done <= finish || (done && !rd_stat);
      if (rd_auth && !busy) rdy <= 1'b0;
      if (wr_sel && !busy) begin
        nbyte <= '0;
        fresh <= sel_ok;
        if (sel_ok) begin
          coef_sel <= wr_data[3:2];
          seed_sel <= wr_data[1:0];
          coef_key <= key_of(wr_data[3:2]);
          seed_key <= key_of(wr_data[1:0]);
        end
      end else if (wr_chl && !busy) begin
        chal[{nbyte, 3'b000} +: 8] <= wr_data;
        nbyte <= nbyte + 2'd1;
      end
      if (start) begin
        h     <= seed_key ^ {wr_data, chal[23:0]};
        busy  <= 1'b1;
        step  <= '0;
        fresh <= 1'b0;
        rdy   <= 1'b0;
      end else if (busy) begin
        h    <= {h[28:0], h[31:29]} ^ (coef_key + 32'(step));
        step <= step + 1'b1;
        if (finish) begin
          busy <= 1'b0;
          rdy  <= 1'b1;
        end
      end
    end
  end

  p_bad_sel_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel && !busy && !sel_ok |=> $stable({coef_sel, seed_sel}) && err);
  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && fresh |=> busy && !rdy);
  p_end_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> rdy && done);
  p_read_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_auth && rdy && !busy |=> !rdy);
  p_busy_read_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_auth && busy |=> err);
  p_stale_sel_r8: assert property (@(posedge clk) disable iff (!rst_n)
    last_byte && !fresh |=> !busy && err);
  p_sel_drops_bytes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel && !busy |=> nbyte == 2'd0);
  p_done_survives_r10: assert property (@(posedge clk) disable iff (!rst_n)
    finish && rd_stat |=> done);
  p_busy_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel || wr_chl) && busy |=> err && $stable(chal) && $stable(coef_key));
endmodule

// File: tb/test_auth_regfront.sv
module test_auth_regfront;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] page = '0;
  logic [3:0] offset = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  auth_regfront i_auth_regfront (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .page(page), .offset(offset), .wr_data(wr_data), .rd_data(rd_data));

  localparam logic [35:0] VEC [0:5] = '{
    {2'd1, 2'd2, 32'h0000_0000}, {2'd3, 2'd1, 32'hDEAD_BEEF},
    {2'd2, 2'd3, 32'h1234_5678}, {2'd1, 2'd1, 32'hFFFF_FFFF},
    {2'd3, 2'd3, 32'h8000_0001}, {2'd2, 2'd2, 32'h0F0F_A5A5}};

  function automatic logic [31:0] secret(input logic [1:0] c);
    case (c)
      2'd1: return 32'hA5C3_1E69;
      2'd2: return 32'h3C96_F00D;
      default: return 32'h7E15_92B4;
    endcase
  endfunction

  function automatic logic [7:0] model(input logic [1:0] c, input logic [1:0] s, input logic [31:0] x);
    logic [31:0] v;
    v = secret(s) ^ x;
    for (int i = 0; i < 8; i++) v = {v[28:0], v[31:29]} ^ (secret(c) + 32'(i));
    return v[31:24] ^ v[23:16] ^ v[15:8] ^ v[7:0];
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] p, input logic [3:0] o, input logic [7:0] d);
    @(negedge clk); page = p; offset = o; wr_data = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] p, input logic [3:0] o, output logic [7:0] d);
    @(negedge clk); page = p; offset = o; rd_en = 1'b1;
    #1 d = rd_data;
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic chal4(input logic [31:0] c);
    for (int b = 0; b < 4; b++) wr(2'd2, 4'h1, c[8*b +: 8]);
  endtask

  task automatic expect_rd(input string req, input logic [1:0] p, input logic [3:0] o, input logic [7:0] exp);
    logic [7:0] d;
    rd(p, o, d);
    chk(req, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    expect_rd("R1 sel reset", 2'd2, 4'h0, 8'h06);
    expect_rd("R1 status reset", 2'd1, 4'h1, 8'h00);

    chal4(32'h1122_3344);
    expect_rd("R8 no selection since reset", 2'd1, 4'h1, 8'h02);
    expect_rd("R10 error cleared by read", 2'd1, 4'h1, 8'h00);

    for (int v = 0; v < 6; v++) begin
      logic [1:0] c, s;
      logic [31:0] x;
      {c, s, x} = VEC[v];
      wr(2'd2, 4'h0, {4'h0, c, s});
      expect_rd("R2 selection readback", 2'd2, 4'h0, {4'h0, c, s});
      chal4(x);
      for (int k = 1; k <= 9; k++)
        expect_rd(k <= 8 ? "R4 busy window" : "R10 done kept on same-cycle read",
                  2'd1, 4'h1, k <= 8 ? 8'h01 : 8'h04);
      expect_rd("R5 R3 result", 2'd2, 4'h5, model(c, s, x));
      expect_rd("R10 done cleared", 2'd1, 4'h1, 8'h00);
    end

    expect_rd("R6 second read", 2'd2, 4'h5, 8'h00);
    expect_rd("R6 error flagged", 2'd1, 4'h1, 8'h02);

    chal4(32'h5555_AAAA);
    expect_rd("R8 reuse of old selection", 2'd1, 4'h1, 8'h02);

    wr(2'd2, 4'h0, 8'h0C);
    expect_rd("R2 seed 00 rejected", 2'd2, 4'h0, 8'h0A);
    expect_rd("R2 seed 00 error", 2'd1, 4'h1, 8'h02);
    wr(2'd2, 4'h0, 8'h01);
    expect_rd("R2 coef 00 rejected", 2'd2, 4'h0, 8'h0A);
    expect_rd("R2 coef 00 error", 2'd1, 4'h1, 8'h02);

    wr(2'd2, 4'h0, 8'h07);
    wr(2'd2, 4'h1, 8'hAA);
    wr(2'd2, 4'h1, 8'hBB);
    wr(2'd2, 4'h0, 8'h07);
    chal4(32'hCAFE_0042);
    expect_rd("R7 read while busy", 2'd2, 4'h5, 8'h00);
    expect_rd("R7 busy and error", 2'd1, 4'h1, 8'h03);
    repeat (10) @(posedge clk);
    expect_rd("R9 partial challenge dropped", 2'd2, 4'h5, model(2'd1, 2'd3, 32'hCAFE_0042));
    expect_rd("R9 done only", 2'd1, 4'h1, 8'h04);

    wr(2'd2, 4'h0, 8'h05);
    chal4(32'h0102_0304);
    wr(2'd2, 4'h0, 8'h0F);
    wr(2'd2, 4'h1, 8'h99);
    repeat (10) @(posedge clk);
    expect_rd("R11 selection unchanged", 2'd2, 4'h0, 8'h05);
    expect_rd("R11 result uses old keys", 2'd2, 4'h5, model(2'd1, 2'd1, 32'h0102_0304));
    expect_rd("R11 done and error", 2'd1, 4'h1, 8'h06);
    wr(2'd2, 4'h0, 8'h05);
    chal4(32'h0A0B_0C0D);
    repeat (10) @(posedge clk);
    expect_rd("R11 counter unharmed", 2'd2, 4'h5, model(2'd1, 2'd1, 32'h0A0B_0C0D));
    expect_rd("R11 clean status", 2'd1, 4'h1, 8'h04);

    wr(2'd0, 4'h0, 8'hFF);
    wr(2'd3, 4'h5, 8'h00);
    wr(2'd1, 4'h1, 8'hFF);
    expect_rd("R12 unmapped read", 2'd0, 4'h0, 8'h00);
    expect_rd("R3 challenge write-only", 2'd2, 4'h1, 8'h00);
    expect_rd("R12 selection untouched", 2'd2, 4'h0, 8'h05);
    expect_rd("R12 no status change", 2'd1, 4'h1, 8'h00);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule